// File: doc/BRIEF.md
# Conditional Execute Stage with Operand Forwarding

This block is the execute step of a small in-order pipeline for a 32-bit conditional instruction set reduced to add, move, compare, word load/store with a register or immediate offset, and branch with optional link. Each cycle it takes an instruction word, the program counter value and two operands read by the decode step. It evaluates the condition field against a 4-bit flag register. It then produces the register write request, the branch redirect, the pipeline flush and the memory access request.

Operands can be stale because of pipelining, so the stage replaces them from two places. The first is the result of the instruction it executed just before, held inside the stage. The second is a result offered by the memory step. Every result is registered on one output stage. When the enable input is low, that stage holds its contents and drops the ready flag.

Top module: `exec_stage`

## Requirements
- R1: While reset is asserted, every output is zero, ready is low and the flag register reads 0000. Flag bits are N=bit 3, Z=bit 2, C=bit 1, V=bit 0.
- R2: An instruction presented while enable is high at a rising clock edge has all of its results on the outputs after that edge, and ready is high from that edge on.
- R3: A rising edge with enable low leaves every result output and the flag register unchanged whatever the inputs are, and ready reads low after it.
- R4: The condition code sits in bits [31:28]: 0 EQ, 1 NE, 2 CS, 3 CC, 4 MI, 5 PL, 6 VS, 7 VC, 8 HI, 9 LS, 10 GE, 11 LT, 12 GT, 13 LE, 14 always, 15 never. It is evaluated against the flags held before the instruction. On a failing condition, condPass is low and the register update, PC update, flush and memory write are all low, and the flags are unchanged.
- R5: A compare (bits [27:26]=00, opcode [24:21]=1010) loads the flags from Rn minus operand 2. C is set when no borrow occurs and V on signed overflow. It raises neither updRd nor flushPc.
- R6: Add (opcode 0100) gives Rn plus operand 2 and move (opcode 1101) gives operand 2, both with updRd high. Operand 2 is one of two forms:
  - Bit 25 set: the immediate [7:0] rotated right by twice [11:8].
  - Bit 25 clear: Rm ([3:0]) shifted by type [6:5] (LSL, LSR, ASR, ROR) and amount [11:7], where an amount of 0 means no shift.
  
  A destination of register 15 also raises flushPc but not updPc.
- R7: For a memory instruction (bits [27:26]=01), the address is Rn plus the shifted Rm when bit 25 is set, or plus the 12-bit immediate [11:0] when it is clear. A load (bit 20 set) raises updRd and puts the address on memRdAddr without any write. A store raises memWrEn with that address and the Rd ([15:12]) operand as data, and does not raise updRd.
- R8: A branch (bits [27:26]=10) sets newPc to the PC input plus the sign-extended 24-bit offset times 4, and raises updPc and flushPc. With bit 24 set (link), it also raises updRd with value PC input minus 4.
- R9: When the previous executed add, move or link branch wrote the register an operand names, its result replaces the decoder value for that operand.
- R10: When memFwdValid is high and memFwdAddr matches an operand register, memFwdValue replaces that operand. If both forwarding sources match, the previous-result source wins.
- R11: An operand naming register 15 always uses the decoder value; no forwarding source applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Advance the stage this cycle |
| pcIn | input | 32 | PC of the instruction plus 8 |
| instIn | input | 32 | Instruction word |
| rnIn | input | 32 | Decoder value of Rn |
| rdRmIn | input | 32 | Decoder value of Rm, or of Rd for a store |
| memFwdValid | input | 1 | Memory step offers a result |
| memFwdAddr | input | 4 | Register written by that result |
| memFwdValue | input | 32 | Value of that result |
| ready | output | 1 | Outputs carry a fresh result |
| updRd | output | 1 | Write the destination register |
| rdValue | output | 32 | Value for the destination register |
| updPc | output | 1 | Redirect the PC |
| newPc | output | 32 | Branch target |
| flushPc | output | 1 | Discard younger instructions |
| memRdAddr | output | 32 | Load address |
| memWrEn | output | 1 | Store request |
| memWrAddr | output | 32 | Store address |
| memWrData | output | 32 | Store data |
| cpsr | output | 4 | Flags N,Z,C,V (bits 3..0) |
| condPass | output | 1 | Condition of the last instruction held |

## Verification
Every result, including the flags and condPass, appears one clock edge after the instruction is driven. The bench therefore drives at the falling edge and reads the outputs 1 ns after the next rising edge, before the next stimulus. Forwarding depends on the previous row, so the vector table runs as one ordered sequence in which each expected value already reflects the row before it. The hold test drives new inputs with enable low and reads the outputs after the same single edge, then again after re-enabling.

// File: rtl/exs_pkg.sv
package exs_pkg;

  // flag bit positions inside the 4-bit flag register
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef struct packed {
    logic isData;
    logic isMem;
    logic isBranch;
    logic isLoad;
    logic link;
    logic opAdd;
    logic opMov;
    logic opCmp;
    logic condOk;
  } exs_strobe_t;

  function automatic logic condHolds(input logic [3:0] code, input logic [3:0] f);
    logic n, z, c, v;
    n = f[FLAG_N];
    z = f[FLAG_Z];
    c = f[FLAG_C];
    v = f[FLAG_V];
    case (code)
      4'h0:    return z;
      4'h1:    return !z;
      4'h2:    return c;
      4'h3:    return !c;
      4'h4:    return n;
      4'h5:    return !n;
      4'h6:    return v;
      4'h7:    return !v;
      4'h8:    return c && !z;
      4'h9:    return !c || z;
      4'hA:    return n == v;
      4'hB:    return n != v;
      4'hC:    return !z && (n == v);
      4'hD:    return z || (n != v);
      4'hE:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/exs_ctrl.sv
module exs_ctrl
  import exs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic [5:0]  instHi,    // cond [31:28], class [27:26]
  input  logic [4:0]  instMid,   // [24:20]
  input  logic [3:0]  cmpFlags,
  output exs_strobe_t stb,
  output logic [3:0]  cpsr,
  output logic        condPass
);

  logic [3:0] condCode;
  logic [1:0] instClass;
  logic [3:0] opCode;

  assign condCode  = instHi[5:2];
  assign instClass = instHi[1:0];
  assign opCode    = instMid[4:1];

  always_comb begin
    stb          = '0;
    stb.isData   = (instClass == 2'b00);
    stb.isMem    = (instClass == 2'b01);
    stb.isBranch = (instClass == 2'b10);
    stb.isLoad   = instMid[0];
    stb.link     = instMid[4];
    stb.opAdd    = stb.isData && (opCode == 4'b0100);
    stb.opMov    = stb.isData && (opCode == 4'b1101);
    stb.opCmp    = stb.isData && (opCode == 4'b1010);
    stb.condOk   = condHolds(condCode, cpsr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpsr     <= 4'b0000;
      condPass <= 1'b0;
    end else if (enable) begin
      condPass <= stb.condOk;
      if (stb.opCmp && stb.condOk) cpsr <= cmpFlags;
    end
  end

  a_r5_flags_only_cmp: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && stb.opCmp && stb.condOk) |=> $stable(cpsr));

endmodule

// File: rtl/exs_datapath.sv
module exs_datapath
  import exs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  exs_strobe_t       stb,
  input  logic              immSel,     // instruction bit 25
  input  logic [23:0]       instLo,     // instruction bits [23:0]
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] rnIn,
  input  logic [DATA_W-1:0] rdRmIn,
  input  logic              memFwdValid,
  input  logic [REG_AW-1:0] memFwdAddr,
  input  logic [DATA_W-1:0] memFwdValue,
  output logic [3:0]        cmpFlags,
  output logic              ready,
  output logic              updRd,
  output logic [DATA_W-1:0] rdValue,
  output logic              updPc,
  output logic [DATA_W-1:0] newPc,
  output logic              flushPc,
  output logic [DATA_W-1:0] memRdAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);

  localparam int SHW = $clog2(DATA_W) + 1;
  localparam logic [REG_AW-1:0] PC_IDX   = '1;
  localparam logic [REG_AW-1:0] LINK_IDX = PC_IDX - REG_AW'(1);

  // instruction fields
  logic [REG_AW-1:0] rnIdx, rdIdx, rmIdx, slot2Idx, dstIdx;
  assign rnIdx    = REG_AW'(instLo[19:16]);
  assign rdIdx    = REG_AW'(instLo[15:12]);
  assign rmIdx    = REG_AW'(instLo[3:0]);
  assign slot2Idx = (stb.isMem && !stb.isLoad) ? rdIdx : rmIdx;
  assign dstIdx   = stb.isBranch ? LINK_IDX : rdIdx;

  // own-result forwarding state
  logic              ownValid;
  logic [REG_AW-1:0] ownAddr;
  logic [DATA_W-1:0] ownVal;

  function automatic logic [DATA_W-1:0] pickOperand(
    input logic [REG_AW-1:0] idx, input logic [DATA_W-1:0] decVal,
    input logic oV, input logic [REG_AW-1:0] oA, input logic [DATA_W-1:0] oD,
    input logic mV, input logic [REG_AW-1:0] mA, input logic [DATA_W-1:0] mD);
    if (idx == PC_IDX)           return decVal;
    if (oV && (oA == idx))       return oD;
    if (mV && (mA == idx))       return mD;
    return decVal;
  endfunction

  function automatic logic [DATA_W-1:0] rotR(input logic [DATA_W-1:0] x,
                                             input logic [SHW-1:0] amt);
    return (x >> amt) | (x << (SHW'(DATA_W) - amt));
  endfunction

  function automatic logic [DATA_W-1:0] shiftOp(input logic [DATA_W-1:0] x,
                                                input logic [1:0] kind,
                                                input logic [SHW-1:0] amt);
    case (kind)
      2'b00:   return x << amt;
      2'b01:   return x >> amt;
      2'b10:   return DATA_W'($signed(x) >>> amt);
      default: return rotR(x, amt);
    endcase
  endfunction

  logic [DATA_W-1:0] opA, opB, shifted, rotImm, op2, aluSum, memOff, memAddr;
  logic [DATA_W-1:0] brOff, target, resVal;
  logic [DATA_W:0]   diffExt;
  logic              wrRd, wrPc, doFlush, doStore, ownNext;

  always_comb begin
    opA     = pickOperand(rnIdx, rnIn, ownValid, ownAddr, ownVal,
                          memFwdValid, memFwdAddr, memFwdValue);
    opB     = pickOperand(slot2Idx, rdRmIn, ownValid, ownAddr, ownVal,
                          memFwdValid, memFwdAddr, memFwdValue);
    shifted = shiftOp(opB, instLo[6:5], SHW'(instLo[11:7]));
    rotImm  = rotR(DATA_W'(instLo[7:0]), SHW'({instLo[11:8], 1'b0}));
    op2     = immSel ? rotImm : shifted;
    aluSum  = opA + op2;
    diffExt = {1'b0, opA} - {1'b0, op2};
    cmpFlags[FLAG_N] = diffExt[DATA_W-1];
    cmpFlags[FLAG_Z] = (diffExt[DATA_W-1:0] == '0);
    cmpFlags[FLAG_C] = !diffExt[DATA_W];
    cmpFlags[FLAG_V] = (opA[DATA_W-1] != op2[DATA_W-1]) &&
                       (diffExt[DATA_W-1] != opA[DATA_W-1]);
    memOff  = immSel ? shifted : DATA_W'(instLo[11:0]);
    memAddr = opA + memOff;
    brOff   = {{(DATA_W-26){instLo[23]}}, instLo[23:0], 2'b00};
    target  = pcIn + brOff;
    if (stb.isBranch)   resVal = pcIn - DATA_W'(4);
    else if (stb.opMov) resVal = op2;
    else                resVal = aluSum;
    ownNext = stb.condOk && (stb.opAdd || stb.opMov || (stb.isBranch && stb.link));
    wrRd    = ownNext || (stb.condOk && stb.isMem && stb.isLoad);
    wrPc    = stb.condOk && stb.isBranch;
    doFlush = wrPc || (stb.condOk && (stb.opAdd || stb.opMov) && (rdIdx == PC_IDX));
    doStore = stb.condOk && stb.isMem && !stb.isLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready     <= 1'b0;
      updRd     <= 1'b0;
      rdValue   <= '0;
      updPc     <= 1'b0;
      newPc     <= '0;
      flushPc   <= 1'b0;
      memRdAddr <= '0;
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
      ownValid  <= 1'b0;
      ownAddr   <= '0;
      ownVal    <= '0;
    end else begin
      ready <= enable;
      if (enable) begin
        updRd     <= wrRd;
        rdValue   <= resVal;
        updPc     <= wrPc;
        newPc     <= target;
        flushPc   <= doFlush;
        memRdAddr <= memAddr;
        memWrEn   <= doStore;
        memWrAddr <= memAddr;
        memWrData <= opB;
        ownValid  <= ownNext;
        ownAddr   <= dstIdx;
        ownVal    <= resVal;
      end
    end
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !ready && $stable(updRd) && $stable(rdValue) && $stable(updPc) &&
                $stable(newPc) && $stable(flushPc) && $stable(memWrEn) &&
                $stable(memWrAddr) && $stable(memWrData) && $stable(memRdAddr));

  a_r2_ready: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> ready);

  a_r4_fail_quiet: assert property (@(posedge clk) disable iff (!rstN)
    enable && !stb.condOk |=> !updRd && !updPc && !flushPc && !memWrEn);

  a_r8_redirect_flushes: assert property (@(posedge clk) disable iff (!rstN)
    updPc |-> flushPc);

endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [31:0]       instIn,
  input  logic [DATA_W-1:0] rnIn,
  input  logic [DATA_W-1:0] rdRmIn,
  input  logic              memFwdValid,
  input  logic [REG_AW-1:0] memFwdAddr,
  input  logic [DATA_W-1:0] memFwdValue,
  output logic              ready,
  output logic              updRd,
  output logic [DATA_W-1:0] rdValue,
  output logic              updPc,
  output logic [DATA_W-1:0] newPc,
  output logic              flushPc,
  output logic [DATA_W-1:0] memRdAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [3:0]        cpsr,
  output logic              condPass
);

  exs_strobe_t stb;
  logic [3:0]  cmpFlags;

  exs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .instHi   (instIn[31:26]),
    .instMid  (instIn[24:20]),
    .cmpFlags (cmpFlags),
    .stb      (stb),
    .cpsr     (cpsr),
    .condPass (condPass)
  );

  exs_datapath #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .stb         (stb),
    .immSel      (instIn[25]),
    .instLo      (instIn[23:0]),
    .pcIn        (pcIn),
    .rnIn        (rnIn),
    .rdRmIn      (rdRmIn),
    .memFwdValid (memFwdValid),
    .memFwdAddr  (memFwdAddr),
    .memFwdValue (memFwdValue),
    .cmpFlags    (cmpFlags),
    .ready       (ready),
    .updRd       (updRd),
    .rdValue     (rdValue),
    .updPc       (updPc),
    .newPc       (newPc),
    .flushPc     (flushPc),
    .memRdAddr   (memRdAddr),
    .memWrEn     (memWrEn),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData)
  );

endmodule

// File: tb/test_exec_stage.sv
`timescale 1ns/1ps
module test_exec_stage;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] pcIn = '0, instIn = '0, rnIn = '0, rdRmIn = '0, memFwdValue = '0;
  logic        memFwdValid = 1'b0;
  logic [3:0]  memFwdAddr = '0;
  logic        ready, updRd, updPc, flushPc, memWrEn, condPass;
  logic [31:0] rdValue, newPc, memRdAddr, memWrAddr, memWrData;
  logic [3:0]  cpsr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exec_stage i_exec_stage (
    .clk(clk), .rstN(rstN), .enable(enable), .pcIn(pcIn), .instIn(instIn),
    .rnIn(rnIn), .rdRmIn(rdRmIn), .memFwdValid(memFwdValid),
    .memFwdAddr(memFwdAddr), .memFwdValue(memFwdValue), .ready(ready),
    .updRd(updRd), .rdValue(rdValue), .updPc(updPc), .newPc(newPc),
    .flushPc(flushPc), .memRdAddr(memRdAddr), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .cpsr(cpsr),
    .condPass(condPass)
  );

  typedef struct packed {
    logic [31:0] inst;
    logic [31:0] pc;
    logic [31:0] rn;
    logic [31:0] rm;
    logic        fwV;
    logic [3:0]  fwA;
    logic [31:0] fwD;
    logic        eUpd;
    logic [31:0] eRd;
    logic        eUpdPc;
    logic [31:0] eNp;
    logic        eFl;
    logic        eMw;
    logic [31:0] eMa;
    logic [31:0] eMd;
    logic [3:0]  eFlags;
    logic        ePass;
    logic        chkRd;
    logic        chkLd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // add r4,r6,r7
    '{32'he0864007, 0, 3, 5, 0, 0, 0,  1, 8, 0, 0, 0, 0, 0, 0, 4'b0000, 1, 1, 0},
    // cmp r4,r5 : r4 comes from the previous add (8)
    '{32'he1540005, 0, 32'hffff, 8, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0, 0, 4'b0110, 1, 0, 0},
    // movne lr,#0 : fails
    '{32'h13a0e000, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0, 0, 4'b0110, 0, 0, 0},
    // moveq pc,lr
    '{32'h01a0f00e, 0, 0, 42, 0, 0, 0,  1, 42, 0, 0, 1, 0, 0, 0, 4'b0110, 1, 1, 0},
    // add r0,pc,r4 : r15 offered by both sources but never forwarded
    '{32'he08f0004, 0, 100, 5, 1, 15, 77,  1, 105, 0, 0, 0, 0, 0, 0, 4'b0110, 1, 1, 0},
    // ldr r4,[r8,r9,lsr #5]
    '{32'he79842a9, 0, 4, 32'h60, 0, 0, 0,  1, 0, 0, 0, 0, 0, 7, 0, 4'b0110, 1, 0, 1},
    // mov r5,r4 : r4 from memory step
    '{32'he1a05004, 0, 42, 32'hdeadbeef, 1, 4, 32'hbabafafa,  1, 32'hbabafafa, 0, 0, 0, 0, 0, 0, 4'b0110, 1, 1, 0},
    // str r5,[r8] : both sources match r5, own result wins
    '{32'he5885000, 0, 1, 32'h11111111, 1, 5, 32'h22222222,  0, 0, 0, 0, 0, 1, 1, 32'hbabafafa, 4'b0110, 1, 0, 0},
    // mov r4,r5 : only the memory step matches
    '{32'he1a04005, 0, 42, 32'h44444444, 1, 5, 32'h33333333,  1, 32'h33333333, 0, 0, 0, 0, 0, 0, 4'b0110, 1, 1, 0},
    // b -6 words
    '{32'heafffffa, 28, 0, 0, 0, 0, 0,  0, 0, 1, 4, 1, 0, 0, 0, 4'b0110, 1, 0, 0},
    // bl -5 words
    '{32'hebfffffb, 24, 0, 0, 0, 0, 0,  1, 20, 1, 4, 1, 0, 0, 0, 4'b0110, 1, 1, 0},
    // mov r6,lr : link value forwarded
    '{32'he1a0600e, 0, 0, 99, 0, 0, 0,  1, 20, 0, 0, 0, 0, 0, 0, 4'b0110, 1, 1, 0},
    // cmp r1,r2 : 0x80000000 - 1 -> C and V
    '{32'he1510002, 0, 32'h80000000, 1, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0, 0, 4'b0011, 1, 0, 0},
    // movlt r3,r1 : passes
    '{32'hb1a03001, 0, 0, 7, 0, 0, 0,  1, 7, 0, 0, 0, 0, 0, 0, 4'b0011, 1, 1, 0},
    // addge r4,r6,r7 : fails
    '{32'ha0864007, 0, 3, 5, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0, 0, 4'b0011, 0, 0, 0},
    // mov r7,#0xff ror 8
    '{32'he3a074ff, 0, 0, 0, 0, 0, 0,  1, 32'hff000000, 0, 0, 0, 0, 0, 0, 4'b0011, 1, 1, 0},
    // never condition
    '{32'hf0864007, 0, 3, 5, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0, 0, 4'b0011, 0, 0, 0}
  };

  function automatic string rowReq(input int i);
    case (i)
      0, 3, 15: return "R6";
      1, 11:    return "R9";
      2, 13, 14, 16: return "R4";
      4:        return "R11";
      5:        return "R7";
      6, 7, 8:  return "R10";
      9, 10:    return "R8";
      default:  return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] inst, pc, rn, rm,
                       input logic fv, input logic [3:0] fa, input logic [31:0] fd);
    instIn = inst; pcIn = pc; rnIn = rn; rdRmIn = rm;
    memFwdValid = fv; memFwdAddr = fa; memFwdValue = fd;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "ready", 32'(ready), 0);
    chk("R1", "updRd", 32'(updRd), 0);
    chk("R1", "rdValue", rdValue, 0);
    chk("R1", "flushPc", 32'(flushPc), 0);
    chk("R1", "memWrEn", 32'(memWrEn), 0);
    chk("R1", "cpsr", 32'(cpsr), 0);
    @(negedge clk);
    rstN = 1'b1;
    enable = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].inst, VECS[i].pc, VECS[i].rn, VECS[i].rm,
            VECS[i].fwV, VECS[i].fwA, VECS[i].fwD);
      @(posedge clk);
      #1;
      chk("R2", $sformatf("row%0d ready", i), 32'(ready), 1);
      chk(rowReq(i), $sformatf("row%0d updRd", i), 32'(updRd), 32'(VECS[i].eUpd));
      chk(rowReq(i), $sformatf("row%0d flushPc", i), 32'(flushPc), 32'(VECS[i].eFl));
      chk("R8", $sformatf("row%0d updPc", i), 32'(updPc), 32'(VECS[i].eUpdPc));
      chk("R7", $sformatf("row%0d memWrEn", i), 32'(memWrEn), 32'(VECS[i].eMw));
      chk("R5", $sformatf("row%0d cpsr", i), 32'(cpsr), 32'(VECS[i].eFlags));
      chk("R4", $sformatf("row%0d condPass", i), 32'(condPass), 32'(VECS[i].ePass));
      if (VECS[i].chkRd) chk(rowReq(i), $sformatf("row%0d rdValue", i), rdValue, VECS[i].eRd);
      if (VECS[i].eUpdPc) chk("R8", $sformatf("row%0d newPc", i), newPc, VECS[i].eNp);
      if (VECS[i].chkLd) chk("R7", $sformatf("row%0d memRdAddr", i), memRdAddr, VECS[i].eMa);
      if (VECS[i].eMw) begin
        chk("R7", $sformatf("row%0d memWrAddr", i), memWrAddr, VECS[i].eMa);
        chk("R7", $sformatf("row%0d memWrData", i), memWrData, VECS[i].eMd);
      end
      @(negedge clk);
    end

    // R3: enable low holds results and flags
    drive(32'he0864007, 0, 1, 2, 0, 0, 0);  // add r4,r6,r7 -> 3
    @(posedge clk);
    #1;
    chk("R6", "pre-hold rdValue", rdValue, 3);
    @(negedge clk);
    enable = 1'b0;
    drive(32'he1510002, 0, 5, 5, 0, 0, 0);  // cmp equal would set Z
    @(posedge clk);
    #1;
    chk("R3", "hold ready", 32'(ready), 0);
    chk("R3", "hold rdValue", rdValue, 3);
    chk("R3", "hold updRd", 32'(updRd), 1);
    chk("R3", "hold cpsr", 32'(cpsr), 32'(4'b0011));
    @(negedge clk);
    drive(32'heafffffa, 28, 0, 0, 0, 0, 0); // branch while disabled
    @(posedge clk);
    #1;
    chk("R3", "hold updPc", 32'(updPc), 0);
    chk("R3", "hold flushPc", 32'(flushPc), 0);
    @(negedge clk);
    // R2: re-enable, mov r5,r4 forwards held add result 3
    enable = 1'b1;
    drive(32'he1a05004, 0, 0, 9, 0, 0, 0);
    @(posedge clk);
    #1;
    chk("R2", "re-enable ready", 32'(ready), 1);
    chk("R9", "forward across hold", rdValue, 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule